// File: doc/BRIEF.md
# Memory Slave with Registered Read Output and Matched Ready

An AHB-Lite memory slave that keeps a small array of data words. For timing closure, its read word passes through an output register. The ready logic is built as a pair with that register. When a read reaches its completing cycle, the cycle in which the slave raises HREADYOUT, the registered word is already valid on HRDATA. The master samples read data only in that cycle, so the slave never completes a read before its data is valid. This rules out handing the master a stale or undefined word.

A small state machine tracks the data phase that is in progress. `S_IDLE` means no data phase is pending, or the pending transfer was IDLE, BUSY or not selected. `S_WR` is a write data phase. `S_RD_WAIT` is the single wait cycle of a read, in which the output register loads. `S_RD_LAST` is the completing cycle of a read.

From `S_IDLE`, `S_WR` or `S_RD_LAST`, an accepted address phase moves the machine as follows:
- a write goes to `S_WR`;
- a read goes to `S_RD_WAIT` when the read is registered, or straight to `S_RD_LAST` in the unregistered variant;
- no accepted transfer returns the machine to `S_IDLE`.

`S_RD_WAIT` always moves to `S_RD_LAST`. The parameter `REG_READ` set to 0 gives the unregistered variant for comparison. In that variant, reads complete with no wait state from a combinational read path.

Top module: `ahbrr_slave`

## Requirements
- R1: After reset, HREADYOUT is 1, HRDATA is zero and HRESP is 0 (OKAY).
- R2: An address phase is accepted only when HSEL and HREADY are both 1 and HTRANS[1] is 1 (NONSEQ = 2'b10, SEQ = 2'b11). A transfer that is not accepted leaves the stored words unchanged.
- R3: An accepted write stores HWDATA into word index HADDR[5:2] (16 words by default) during its data phase, and completes with HREADYOUT 1 and no wait state.
- R4: With REG_READ = 1, an accepted read holds HREADYOUT at 0 for exactly one cycle and then raises it. In that completing cycle, HRDATA equals the word stored at the latched index.
- R5: With REG_READ = 1, HRDATA stays stable for the whole completing cycle. It keeps the last read word while writes, idle cycles and unselected transfers follow, until the next read loads it.
- R6: A read that immediately follows a write to the same word returns the newly written data.
- R7: IDLE (2'b00), BUSY (2'b01) and unselected transfers get a zero-wait response.
- R8: HRESP is 0 (OKAY) in every cycle.
- R9: With REG_READ = 0, reads complete with no wait state, and HRDATA carries the stored word in that same cycle.
- R10: HSIZE does not affect behaviour. Every write replaces the full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address of the address phase |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size (not used, full word) |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready, previous transfer done |
| hrdata | output | DATA_W | Read data |
| hreadyout | output | 1 | Slave ready for the current data phase |
| hresp | output | 1 | Response, always OKAY |

## Verification
Two events can fall in the same cycle. One is the completion of a data phase. The other is the acceptance of the next address phase, which may be a read of the word that the completing write is storing. Back-to-back write/read pairs to the same index provoke this, both with and without the register stage. The bench judges each read only in the cycle where ready is high, against a model updated at write completion. It also counts the wait cycles before that completion, and samples HRDATA twice in the completing cycle to confirm it does not move.

// File: rtl/ahbrr_pkg.sv
package ahbrr_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_WR      = 2'd1,
        S_RD_WAIT = 2'd2,
        S_RD_LAST = 2'd3
    } phase_e;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic RESP_OKAY = 1'b0;

endpackage

// File: rtl/ahbrr_addr_stage.sv
module ahbrr_addr_stage #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic              hready,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [ADDR_W-1:0] haddr,
    output logic              accept,
    output logic              acc_write,
    output logic [IDX_W-1:0]  idx_q
);

    // NONSEQ and SEQ both have bit 1 set
    assign accept    = hsel && hready && htrans[1];
    assign acc_write = hwrite;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (accept) begin
            idx_q <= haddr[IDX_W+1:2];
        end
    end

endmodule

// File: rtl/ahbrr_ready_fsm.sv
module ahbrr_ready_fsm
    import ahbrr_pkg::*;
#(
    parameter bit REG_READ = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic acc_write,
    output logic hreadyout,
    output logic wr_en,
    output logic rd_load
);

    phase_e state, nxt;

    always_comb begin
        nxt = S_IDLE;
        unique case (state)
            S_RD_WAIT: nxt = S_RD_LAST;
            S_IDLE, S_WR, S_RD_LAST: begin
                if (accept) begin
                    if (acc_write)     nxt = S_WR;
                    else if (REG_READ) nxt = S_RD_WAIT;
                    else               nxt = S_RD_LAST;
                end else begin
                    nxt = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        hreadyout = 1'b1;
        wr_en     = 1'b0;
        rd_load   = 1'b0;
        unique case (state)
            S_IDLE:    hreadyout = 1'b1;
            S_WR:      wr_en     = 1'b1;
            S_RD_WAIT: begin
                hreadyout = 1'b0;
                rd_load   = 1'b1;
            end
            S_RD_LAST: hreadyout = 1'b1;
            default:   hreadyout = 1'b1;
        endcase
    end

    // R3: a write data phase never waits
    a_r3_write_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_write) |=> hreadyout);

    // R4: a low ready lasts exactly one cycle
    a_r4_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !hreadyout |=> hreadyout);

    generate
        if (REG_READ) begin : g_reg_chk
            // R4: a registered read always inserts the wait
            a_r4_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
                (accept && !acc_write) |=> !hreadyout);
        end else begin : g_comb_chk
            // R9: a combinational read completes at once
            a_r9_read_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
                (accept && !acc_write) |=> hreadyout);
        end
    endgenerate

endmodule

// File: rtl/ahbrr_storage.sv
module ahbrr_storage #(
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 16,
    parameter int IDX_W    = 4,
    parameter bit REG_READ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_load,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] word;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr_en && (idx == IDX_W'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    assign word = mem[idx];

    generate
        if (REG_READ) begin : g_reg
            logic [DATA_W-1:0] rdata_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       rdata_q <= '0;
                else if (rd_load) rdata_q <= word;
            end
            assign rdata = rdata_q;
        end else begin : g_comb
            assign rdata = word;
        end
    endgenerate

endmodule

// File: rtl/ahbrr_slave.sv
module ahbrr_slave
    import ahbrr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 16,
    parameter bit REG_READ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic [DATA_W-1:0] hrdata,
    output logic              hreadyout,
    output logic              hresp
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             accept;
    logic             acc_write;
    logic [IDX_W-1:0] idx_q;
    logic             wr_en;
    logic             rd_load;

    // R10: size and the bits outside the word index are not decoded
    logic unused_bits;
    assign unused_bits = ^{hsize, haddr[1:0], haddr[ADDR_W-1:IDX_W+2]};

    ahbrr_addr_stage #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .hready(hready),
        .htrans(htrans), .hwrite(hwrite), .haddr(haddr),
        .accept(accept), .acc_write(acc_write), .idx_q(idx_q)
    );

    ahbrr_ready_fsm #(.REG_READ(REG_READ)) u_fsm (
        .clk(clk), .rst_n(rst_n), .accept(accept), .acc_write(acc_write),
        .hreadyout(hreadyout), .wr_en(wr_en), .rd_load(rd_load)
    );

    ahbrr_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
                    .REG_READ(REG_READ)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_load(rd_load),
        .idx(idx_q), .wdata(hwdata), .rdata(hrdata)
    );

    assign hresp = RESP_OKAY;

    // R7: idle, busy or unselected cycles never produce a wait
    a_r7_idle_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && !(hsel && htrans[1])) |=> hreadyout);

    // R2: no write strobe follows a cycle with no accepted transfer
    a_r2_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && !(hsel && htrans[1])) |=> !wr_en);

endmodule

// File: tb/sim_ahbrr_slave.sv
`timescale 1ns/1ps
module sim_ahbrr_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic        dsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'b010;
    logic [31:0] hwdata = '0;
    logic        hready;
    logic [31:0] rd0, rd1, rdact;
    logic        ro0, ro1, rs0, rs1;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] mdl [2][16];
    logic [31:0] last_rd0 = '0;
    bit          p_v = 0, p_w = 0;
    int          p_idx = 0;
    logic [31:0] p_wd = '0;
    int          waits = 0;

    always #2.5 clk = ~clk;

    assign hready = dsel ? ro1 : ro0;
    assign rdact  = dsel ? rd1 : rd0;

    ahbrr_slave #(.REG_READ(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .hsel(hsel && !dsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
        .hready(hready), .hrdata(rd0), .hreadyout(ro0), .hresp(rs0)
    );

    ahbrr_slave #(.REG_READ(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .hsel(hsel && dsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
        .hready(hready), .hrdata(rd1), .hreadyout(ro1), .hresp(rs1)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // judge the data phase that completes in this cycle
    task automatic complete();
        logic [31:0] first;
        check(rs0 == 1'b0 && rs1 == 1'b0, "R8 okay response", {rs1, rs0}, 0);
        if (p_v && p_w) begin
            check(waits == 0, "R3 write waits", waits, 0);
            mdl[dsel][p_idx] = p_wd;
        end else if (p_v) begin
            check(waits == (dsel ? 0 : 1), dsel ? "R9 read waits" : "R4 read waits",
                  waits, dsel ? 0 : 1);
            check(rdact == mdl[dsel][p_idx], dsel ? "R9 read data" : "R4 R6 read data",
                  rdact, mdl[dsel][p_idx]);
            first = rdact;
            #2;
            if (!dsel) begin
                check(rd0 == first, "R5 stable in completing cycle", rd0, first);
                last_rd0 = first;
            end
        end else begin
            check(waits == 0, "R7 no wait", waits, 0);
            if (!dsel) check(rd0 == last_rd0, "R5 data held", rd0, last_rd0);
        end
    endtask

    task automatic step(input bit sel, input logic [1:0] tr, input bit w,
                        input int idx, input logic [31:0] wd);
        hsel   = sel;
        htrans = tr;
        hwrite = w;
        haddr  = 32'h4000_0000 | (32'(idx) << 2) | 32'(idx % 4);
        hsize  = 3'(idx % 3);   // R10: varies, never matters
        forever begin
            @(negedge clk);
            if (hready) begin
                complete();
                break;
            end
            waits++;
        end
        @(posedge clk);
        #1;
        hwdata = p_v && p_w ? 32'hDEAD_BEEF : 32'h0BAD_0000;
        p_v   = sel && tr[1];
        p_w   = w;
        p_idx = idx;
        p_wd  = wd;
        waits = 0;
        hwdata = (p_v && p_w) ? wd : 32'hFFFF_0000 ^ 32'(idx);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < 2; d++)
            for (int i = 0; i < 16; i++) mdl[d][i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        check(ro0 == 1'b1 && ro1 == 1'b1, "R1 ready at reset", {ro1, ro0}, 2'b11);
        check(rd0 == 32'h0, "R1 read data zero", rd0, 0);
        check(rs0 == 1'b0, "R1 okay at reset", rs0, 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        for (int d = 0; d < 2; d++) begin
            dsel = d[0];
            // R3 fill every word
            for (int i = 0; i < 16; i++)
                step(1, i % 2 ? 2'b11 : 2'b10, 1, i, 32'(i) * 32'h0101_0101 + 32'h5A + 32'(d));
            // R4 / R9 read back-to-back
            for (int i = 15; i >= 0; i--)
                step(1, i % 2 ? 2'b10 : 2'b11, 0, i, 0);
            // R6 write then immediate read of same word, then another read
            for (int i = 0; i < 16; i++) begin
                step(1, 2'b10, 1, i, ~(32'(i) * 32'h1111_0000) ^ 32'(d * 7));
                step(1, 2'b11, 0, i, 0);
                step(1, 2'b11, 0, (i + 5) % 16, 0);
            end
            // R2 / R7 ignored transfers, then reads prove nothing changed
            for (int i = 0; i < 16; i++) begin
                step(0, 2'b10, 1, i, 32'hAAAA_0000);
                step(1, 2'b01, 1, i, 32'hBBBB_0000);
                step(1, 2'b00, 1, i, 32'hCCCC_0000);
                step(1, 2'b10, 0, i, 0);      // R2 word unchanged
            end
            // read, write same word, read again
            for (int i = 0; i < 16; i += 3) begin
                step(1, 2'b10, 0, i, 0);
                step(1, 2'b11, 1, i, 32'h7700_0000 + 32'(i));
                step(1, 2'b00, 0, 0, 0);
                step(1, 2'b10, 0, i, 0);
            end
            step(1, 2'b00, 0, 0, 0);
            step(1, 2'b00, 0, 0, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule